// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the processor reset for a supervised system. Three causes can request a reset: a digital flag saying the supply has dropped under the reset threshold, a flag saying the supply is lower than the backup battery, and a watchdog expiry request. A push-button input with an active-low level is a fourth way in, but only after it has been held long enough to pass a qualification time. Whatever the cause, one shared stretch counter keeps the reset active for a minimum hold time after the cause goes away. For the button, that time is counted from the release of the button.

All durations are counted in ticks. A parameterised prescaler divides the system clock down to one tick (one millisecond in the default setting). The qualification time and the hold time are parameters in ticks, so a testbench can shrink them. The two supply flags and the button pass through a two-flop synchroniser. The watchdog request comes from logic in the same clock domain. An undervoltage status output follows the supply flags with no stretch. The reset is provided both as an active-low output and as its active-high complement.

Top module: `supv_reset_gen`

## Requirements
- R1: Once `sup_under_i` or `sup_lt_batt_i` is high, `cpu_rst_n_o` is low from the second rising clock edge after the change. It stays low for as long as either flag is high.
- R2: After both supply flags have cleared (that is, from the second edge after the clear), `cpu_rst_n_o` stays low for at least HOLD_TICKS ticks. It goes high within HOLD_TICKS+1 ticks, where one tick is CLK_PER_TICK clock cycles.
- R3: A low level on `button_n_i` (low = pressed) starts a reset only when the synchronised low has lasted PB_QUAL_TICKS+1 ticks. A low that lasts fewer than PB_QUAL_TICKS ticks never changes `cpu_rst_n_o`.
- R4: After a qualified press, `cpu_rst_n_o` stays low while the button is held. After the synchronised release it follows the same hold window as R2.
- R5: A one-cycle high pulse on `wdog_expire_i`, which is synchronous to `clk`, drives `cpu_rst_n_o` low from the next edge. The reset then releases after between HOLD_TICKS and HOLD_TICKS+1 ticks.
- R6: A new trigger that arrives while a stretch is running restarts the hold window from its full length.
- R7: `cpu_rst_o` is at all times the inverse of `cpu_rst_n_o`.
- R8: `undervolt_n_o` is low while either supply flag is set, measured at the synchroniser output. It goes high again on the second edge after both flags clear, with no stretch. While it is low, the reset is also active.
- R9: While `sup_lt_batt_i` is high, the button is ignored and its qualification count is held at zero. When the flag clears, qualification of a button that is still pressed starts again from zero.
- R10: While `rst_n` is low, and right after it is released, `cpu_rst_n_o` is low. It goes high after a full hold window once the design leaves reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sup_under_i | input | 1 | Supply below reset threshold (asynchronous) |
| sup_lt_batt_i | input | 1 | Supply below battery voltage (asynchronous) |
| button_n_i | input | 1 | Push-button, low when pressed (asynchronous) |
| wdog_expire_i | input | 1 | Watchdog expiry request, one-cycle pulse in the clk domain |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| cpu_rst_o | output | 1 | Processor reset, active high |
| undervolt_n_o | output | 1 | Undervoltage status, low while supply is bad |

## Verification
The properties treat the expiry request as a clean single-cycle pulse that is already in the clock domain. They also assume the three asynchronous inputs only change at rates much slower than the synchroniser latency, which lets a synchronised level be related to the outputs with no metastability window. The stimulus changes every input shortly after a rising edge and holds each level for many cycles. It only ever raises the watchdog request for one cycle at a time. It also keeps the button lows either clearly shorter or clearly longer than the qualification window, so each expected result does not depend on where the free-running tick falls.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  // Flags carried through the input synchroniser, MSB first.
  typedef struct packed {
    logic under;     // supply below reset threshold
    logic lt_batt;   // supply below battery
    logic button_n;  // push-button level, low = pressed
  } supv_flags_t;

  localparam int unsigned SUPV_FLAG_W = $bits(supv_flags_t);

  // Safe reset image: supply good, button released.
  localparam supv_flags_t SUPV_FLAGS_IDLE = '{under: 1'b0, lt_batt: 1'b0, button_n: 1'b1};

  function automatic int unsigned supv_cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/supv_tick.sv
module supv_tick
  import supv_reset_pkg::*;
#(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned       CW   = supv_cnt_w(DIV - 1);
  localparam logic [CW-1:0]     LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;
  logic [CW-1:0] div_d;
  logic          wrap;

  assign wrap = (div_q == LAST);

  always_comb begin
    div_d = div_q + CW'(1);
    if (wrap) begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick = wrap;

endmodule

// File: rtl/supv_pb_qual.sv
module supv_pb_qual
  import supv_reset_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pressed,
  output logic held
);

  // One extra tick covers the partial first tick period.
  localparam int unsigned   LIM   = QUAL_TICKS + 1;
  localparam int unsigned   CW    = supv_cnt_w(LIM);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic [CW-1:0] qual_q;
  logic [CW-1:0] qual_d;
  logic          qual_en;

  assign qual_en = tick && (qual_q != LIM_C);

  always_comb begin
    qual_d = qual_q;
    if (!pressed) begin
      qual_d = '0;
    end else if (qual_en) begin
      qual_d = qual_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= '0;
    end else begin
      qual_q <= qual_d;
    end
  end

  assign held = (qual_q == LIM_C);

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_reset_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic trig,
  output logic active
);

  localparam int unsigned   LOAD   = HOLD_TICKS + 1;
  localparam int unsigned   CW     = supv_cnt_w(LOAD);
  localparam logic [CW-1:0] LOAD_C = CW'(LOAD);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;
  logic          load_en;
  logic          dec_en;

  assign load_en = hold || trig;
  assign dec_en  = tick && (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (load_en) begin
      left_d = LOAD_C;
    end else if (dec_en) begin
      left_d = left_q - CW'(1);
    end
  end

  // Power-up starts with a full window so reset is asserted out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LOAD_C;
    end else begin
      left_q <= left_d;
    end
  end

  assign active = hold || (left_q != '0);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK  = 50000,
  parameter int unsigned PB_QUAL_TICKS = 40,
  parameter int unsigned HOLD_TICKS    = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_under_i,
  input  logic sup_lt_batt_i,
  input  logic button_n_i,
  input  logic wdog_expire_i,
  output logic cpu_rst_n_o,
  output logic cpu_rst_o,
  output logic undervolt_n_o
);

  supv_flags_t raw;
  supv_flags_t syn;
  logic        tick;
  logic        supply_bad;
  logic        batt_s;
  logic        pb_pressed;
  logic        pb_held;
  logic        rst_active;

  assign raw = '{under: sup_under_i, lt_batt: sup_lt_batt_i, button_n: button_n_i};

  supv_sync #(
    .W       (SUPV_FLAG_W),
    .RST_VAL (SUPV_FLAGS_IDLE)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn)
  );

  supv_tick #(
    .DIV (CLK_PER_TICK)
  ) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign supply_bad = syn.under || syn.lt_batt;
  assign batt_s     = syn.lt_batt;
  // Button is disregarded while running below battery.
  assign pb_pressed = !syn.button_n && !syn.lt_batt;

  supv_pb_qual #(
    .QUAL_TICKS (PB_QUAL_TICKS)
  ) i_pb_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pressed (pb_pressed),
    .held    (pb_held)
  );

  supv_stretch #(
    .HOLD_TICKS (HOLD_TICKS)
  ) i_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .hold   (supply_bad || pb_held),
    .trig   (wdog_expire_i),
    .active (rst_active)
  );

  assign cpu_rst_n_o   = !rst_active;
  assign cpu_rst_o     = rst_active;
  assign undervolt_n_o = !supply_bad;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_rst_n_o,
  input logic cpu_rst_o,
  input logic undervolt_n_o,
  input logic wdog_expire_i,
  input logic tick,
  input logic supply_bad,
  input logic batt_s,
  input logic pb_held
);

  AST_RST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o == !cpu_rst_n_o); // R7

  AST_SUPPLY_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |-> !cpu_rst_n_o); // R1

  AST_UNDERVOLT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !undervolt_n_o |-> !cpu_rst_n_o); // R8

  AST_WDOG_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |=> !cpu_rst_n_o); // R5

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> $past(tick)); // R2

  AST_BUTTON_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pb_held |-> !cpu_rst_n_o); // R4

  AST_BATT_BLOCKS_BUTTON: assert property (@(posedge clk) disable iff (!rst_n)
    batt_s |=> !pb_held); // R9

endmodule

bind supv_reset_gen supv_reset_gen_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_rst_n_o   (cpu_rst_n_o),
  .cpu_rst_o     (cpu_rst_o),
  .undervolt_n_o (undervolt_n_o),
  .wdog_expire_i (wdog_expire_i),
  .tick          (tick),
  .supply_bad    (supply_bad),
  .batt_s        (batt_s),
  .pb_held       (pb_held)
);

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 4;
  localparam int QUAL       = 10;
  localparam int HOLD       = 8;
  localparam int MAX_CYC    = 20000;

  logic clk;
  logic rst_n;
  logic sup_under;
  logic sup_lt_batt;
  logic button_n;
  logic wdog;
  logic cpu_rst_n;
  logic cpu_rst;
  logic uv_n;

  int checks;
  int errors;
  int cyc;
  bit done;

  typedef struct {
    string tag;
    logic  exp_rst_n;
    bit    chk_uv;
    logic  exp_uv_n;
  } exp_t;

  exp_t sb_q[$];

  supv_reset_gen #(
    .CLK_PER_TICK  (CPT),
    .PB_QUAL_TICKS (QUAL),
    .HOLD_TICKS    (HOLD)
  ) i_supv_reset_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_under_i   (sup_under),
    .sup_lt_batt_i (sup_lt_batt),
    .button_n_i    (button_n),
    .wdog_expire_i (wdog),
    .cpu_rst_n_o   (cpu_rst_n),
    .cpu_rst_o     (cpu_rst),
    .undervolt_n_o (uv_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver side: queue an expectation, checked at the following falling edge.
  task automatic expect_rst(input string tag, input logic r);
    exp_t e;
    e.tag = tag; e.exp_rst_n = r; e.chk_uv = 1'b0; e.exp_uv_n = 1'b1;
    sb_q.push_back(e);
  endtask

  task automatic expect_both(input string tag, input logic r, input logic u);
    exp_t e;
    e.tag = tag; e.exp_rst_n = r; e.chk_uv = 1'b1; e.exp_uv_n = u;
    sb_q.push_back(e);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Monitor: pops every queued item at the falling edge and compares.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (cpu_rst_n !== e.exp_rst_n) begin
        errors++;
        $display("FAIL %s: cpu_rst_n_o=%b expected %b at t=%0t", e.tag, cpu_rst_n, e.exp_rst_n, $time);
      end
      checks++;
      if (cpu_rst !== ~cpu_rst_n) begin
        errors++;
        $display("FAIL R7: cpu_rst_o=%b expected %b", cpu_rst, ~cpu_rst_n);
      end
      if (e.chk_uv) begin
        checks++;
        if (uv_n !== e.exp_uv_n) begin
          errors++;
          $display("FAIL %s: undervolt_n_o=%b expected %b", e.tag, uv_n, e.exp_uv_n);
        end
      end
    end
  end

  // Watchdog on the run itself.
  initial begin
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYC && !done) begin
        errors++;
        checks++;
        $display("FAIL run timeout: cycles %0d expected below %0d", cyc, MAX_CYC);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; sup_under = 1'b0; sup_lt_batt = 1'b0; button_n = 1'b1; wdog = 1'b0;
    edges(3);
    @(negedge clk) rst_n = 1'b1;

    // R10: asserted out of reset, released after a full window
    edges(1); expect_rst("R10", 1'b0);
    edges(HOLD*CPT - 4); expect_rst("R10", 1'b0);
    edges(2*CPT + 6); expect_both("R10", 1'b1, 1'b1);

    // R1, R8, R2: supply under threshold
    #1 sup_under = 1'b1;
    edges(1); expect_both("R1", 1'b1, 1'b1);
    edges(1); expect_both("R1", 1'b0, 1'b0);
    edges(20); expect_both("R1", 1'b0, 1'b0);
    #1 sup_under = 1'b0;
    edges(2); expect_both("R8", 1'b0, 1'b1);
    edges(HOLD*CPT); expect_rst("R2", 1'b0);
    edges(CPT); expect_rst("R2", 1'b1);

    // R1: supply below battery
    edges(3); #1 sup_lt_batt = 1'b1;
    edges(2); expect_both("R1", 1'b0, 1'b0);
    edges(10); #1 sup_lt_batt = 1'b0;
    edges(2); expect_both("R8", 1'b0, 1'b1);
    edges(HOLD*CPT); expect_rst("R2", 1'b0);
    edges(CPT); expect_rst("R2", 1'b1);

    // R3: short press is bounce
    edges(3); #1 button_n = 1'b0;
    edges(15); expect_rst("R3", 1'b1);
    edges(15); expect_rst("R3", 1'b1);
    #1 button_n = 1'b1;
    edges(5); expect_rst("R3", 1'b1);

    // R3, R4: qualified press, stretch from release
    edges(3); #1 button_n = 1'b0;
    edges(2 + QUAL*CPT); expect_rst("R3", 1'b1);
    edges(CPT); expect_rst("R3", 1'b0);
    edges(20); expect_rst("R4", 1'b0);
    #1 button_n = 1'b1;
    edges(2 + HOLD*CPT); expect_rst("R4", 1'b0);
    edges(CPT); expect_rst("R4", 1'b1);

    // R5, R6: watchdog pulse and restart
    edges(3); #1 wdog = 1'b1;
    edges(1); expect_rst("R5", 1'b0); #1 wdog = 1'b0;
    edges(19); #1 wdog = 1'b1;
    edges(1); expect_rst("R6", 1'b0); #1 wdog = 1'b0;
    edges(20); expect_rst("R6", 1'b0);
    edges(HOLD*CPT - 20); expect_rst("R6", 1'b0);
    edges(CPT); expect_rst("R5", 1'b1);

    // R9: button ignored on battery, requalifies from zero
    edges(3); #1 button_n = 1'b0; sup_lt_batt = 1'b1;
    edges(2 + (QUAL + 4)*CPT); expect_rst("R9", 1'b0);
    #1 sup_lt_batt = 1'b0;
    edges(2 + HOLD*CPT + CPT + 2); expect_both("R9", 1'b1, 1'b1);
    edges(8); expect_rst("R9", 1'b0);
    #1 button_n = 1'b1;
    edges(2 + (HOLD + 1)*CPT); expect_rst("R4", 1'b1);

    edges(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule